// File: doc/BRIEF.md
# Four-Phase Nested Handshake Sequencer

This block is a clocked sequencing element between two return-to-zero request/acknowledge channels. The upstream side presents a request and receives an acknowledge. The downstream side receives a request and returns an acknowledge. Each upstream request runs one complete four-phase exchange on the downstream side first. The upstream acknowledge is raised only after the downstream acknowledge has returned to zero. The block is used wherever one request has to trigger exactly one full downstream transaction before the requester may go on.

The two incoming handshake lines are asynchronous to the block clock. Each passes through a parameterised flop synchronizer. Upstream request and downstream acknowledge alone cannot tell "downstream request must go up" apart from "downstream request must come down", because both happen while the upstream request is high. A registered phase bit therefore records that the downstream acknowledge has been seen. The phase bit is cleared when the upstream request drops. A sticky flag reports handshake violations by either environment.

Top module: `hs_seq_elem`

## Requirements
- R1: While `rst_n` is low, `right_req`, `left_ack` and `proto_err` are all driven low at the next clock edge and remain low.
- R2: From idle, `right_req` rises exactly SYNC_STAGES+1 clock edges after `left_req` rises (3 edges with the default of 2), while `left_ack` stays low.
- R3: `right_req` falls exactly SYNC_STAGES+2 clock edges after `right_ack` rises (4 edges by default). It never falls earlier while `left_req` is held high.
- R4: `left_ack` stays low while `right_ack` is high. It rises exactly SYNC_STAGES+1 edges after `right_ack` falls (3 by default), with `right_req` already low.
- R5: `left_ack` falls exactly SYNC_STAGES+2 edges after `left_req` falls (4 by default). `right_req` stays low meanwhile.
- R6: In a legal cycle the observed order is: left_req up, right_req up, right_ack up, right_req down, right_ack down, left_ack up, left_req down, left_ack down. The cycle can then repeat any number of times.
- R7: While `left_req` is high and `right_ack` has not risen, `right_req` holds high and `left_ack` holds low for as long as the environment waits.
- R8: A rising `right_ack` while `right_req` is low sets `proto_err`.
- R9: A falling `left_req` while `left_ack` is low sets `proto_err`. A legal run never sets it.
- R10: Once set, `proto_err` stays high until reset.
- R11: In a legal run, `right_req` and `left_ack` never change at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| left_req | input | 1 | Upstream request (asynchronous) |
| left_ack | output | 1 | Upstream acknowledge |
| right_req | output | 1 | Downstream request |
| right_ack | input | 1 | Downstream acknowledge (asynchronous) |
| proto_err | output | 1 | Sticky handshake-violation flag |

## Verification
The bench holds the downstream acknowledge high for random stretches. A design that raised the upstream acknowledge before the downstream side returned to zero would show `left_ack` rising while `right_ack` is still high. A design without a working phase bit would either never drop `right_req` or would re-raise it while `left_req` stays high. The bench measures the latency of every transition exactly, which exposes a missing or extra register stage. It also injects an acknowledge with no request and an early upstream withdrawal. In both cases the error flag must appear and then stay set.

// File: rtl/hsq_pkg.sv
// Shared types and constants for the nested handshake sequencer.
package hsq_pkg;

    // Default synchronizer depth for asynchronous handshake inputs.
    localparam int unsigned HSQ_SYNC_DEFAULT = 2;

    // Registered control state of the sequencer core.
    typedef struct packed {
        logic right_req;   // downstream request
        logic left_ack;    // upstream acknowledge
        logic phase;       // set once downstream acknowledge has been seen
    } hsq_state_t;

    localparam hsq_state_t HSQ_IDLE = '{right_req: 1'b0, left_ack: 1'b0, phase: 1'b0};

endpackage

// File: rtl/hsq_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 1; input is a slowly changing handshake level.
module hsq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
    end

    // Remaining stages shift the level along the chain.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/hsq_core.sv
// Sequencing core: nests one downstream four-phase exchange inside each
// upstream handshake, using a phase bit to tell request-up from request-down.
// Assumes: inputs are already synchronized to clk.
module hsq_core
    import hsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lreq_s,
    input  logic       rack_s,
    output hsq_state_t st
);
    hsq_state_t st_nxt;

    // Next-state equations for the three state bits.
    always_comb begin
        // Phase: set by downstream acknowledge, cleared by upstream withdrawal.
        st_nxt.phase     = lreq_s && (st.phase || rack_s);
        // Downstream request: up while requested and phase still clear.
        st_nxt.right_req = lreq_s && !st.phase;
        // Upstream acknowledge: up once phase set and downstream back to zero.
        st_nxt.left_ack  = st.phase && !rack_s;
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= HSQ_IDLE;
        else        st <= st_nxt;
    end
endmodule

// File: rtl/hsq_monitor.sv
// Handshake violation monitor with a sticky error flag.
// Assumes: inputs are synchronized; outputs are the registered core outputs.
module hsq_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic lreq_s,
    input  logic rack_s,
    input  logic right_req,
    input  logic left_ack,
    output logic err
);
    logic lreq_q;
    logic rack_q;
    logic rack_rise;
    logic lreq_fall;

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lreq_q <= 1'b0;
            rack_q <= 1'b0;
        end else begin
            lreq_q <= lreq_s;
            rack_q <= rack_s;
        end
    end

    // Edge detection on the synchronized inputs.
    always_comb begin
        rack_rise = rack_s && !rack_q;
        lreq_fall = !lreq_s && lreq_q;
    end

    // Sticky flag: unrequested acknowledge or early upstream withdrawal.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= err || (rack_rise && !right_req) || (lreq_fall && !left_ack);
    end
endmodule

// File: rtl/hs_seq_elem.sv
// Top of the nested four-phase handshake sequencer.
// Assumes: both environments keep to return-to-zero signalling; violations
// are only flagged, never corrected.
module hs_seq_elem
    import hsq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = HSQ_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic left_req,
    output logic left_ack,
    output logic right_req,
    input  logic right_ack,
    output logic proto_err
);
    logic       lreq_s;
    logic       rack_s;
    logic       phase;
    hsq_state_t st;

    hsq_sync #(.STAGES(SYNC_STAGES)) i_sync_lreq (
        .clk(clk), .rst_n(rst_n), .d_async(left_req), .q_sync(lreq_s)
    );

    hsq_sync #(.STAGES(SYNC_STAGES)) i_sync_rack (
        .clk(clk), .rst_n(rst_n), .d_async(right_ack), .q_sync(rack_s)
    );

    hsq_core i_core (
        .clk(clk), .rst_n(rst_n), .lreq_s(lreq_s), .rack_s(rack_s), .st(st)
    );

    hsq_monitor i_mon (
        .clk(clk), .rst_n(rst_n), .lreq_s(lreq_s), .rack_s(rack_s),
        .right_req(st.right_req), .left_ack(st.left_ack), .err(proto_err)
    );

    // Expose core state on the ports.
    assign right_req = st.right_req;
    assign left_ack  = st.left_ack;
    assign phase     = st.phase;
endmodule

// File: rtl/hsq_checker.sv
// Protocol properties for the sequencer, attached to the top by bind.
module hsq_checker (
    input logic clk,
    input logic rst_n,
    input logic right_req,
    input logic left_ack,
    input logic proto_err,
    input logic lreq_s,
    input logic rack_s,
    input logic phase
);
    // R1: reset drives all outputs low.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!right_req && !left_ack && !proto_err));

    // R2: downstream request never rises while the upstream acknowledge is high.
    p_req_up_ack_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(right_req) |-> !left_ack);

    // R3: downstream request falls only after acknowledge seen or withdrawal.
    p_req_down_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(right_req) |-> (phase || !lreq_s));

    // R4: upstream acknowledge rises only with downstream side at zero.
    p_ack_up_rtz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(left_ack) |-> (!right_req && !rack_s));

    // R8: unrequested downstream acknowledge sets the error flag.
    p_stray_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rack_s && !$past(rack_s) && !right_req) |=> proto_err);

    // R10: error flag is sticky.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R11: outputs never change together.
    p_single_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(right_req) || $stable(left_ack));
endmodule

bind hs_seq_elem hsq_checker i_hsq_checker (
    .clk(clk), .rst_n(rst_n), .right_req(right_req), .left_ack(left_ack),
    .proto_err(proto_err), .lreq_s(lreq_s), .rack_s(rack_s), .phase(phase)
);

// File: tb/test_hs_seq_elem.sv
module test_hs_seq_elem;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int N_CYCLES = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic left_req = 1'b0;
    logic right_ack = 1'b0;
    logic left_ack;
    logic right_req;
    logic proto_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_seq_elem #(.SYNC_STAGES(SYNC)) i_hs_seq_elem (
        .clk(clk), .rst_n(rst_n), .left_req(left_req), .left_ack(left_ack),
        .right_req(right_req), .right_ack(right_ack), .proto_err(proto_err)
    );

    // Expected latencies derived from the requirements.
    function automatic int lat_short(); return SYNC + 1; endfunction
    function automatic int lat_long();  return SYNC + 2; endfunction

    function automatic logic sig_of(input int which);
        case (which)
            0: return right_req;
            1: return left_ack;
            default: return proto_err;
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Count edges until a chosen output reaches a value (bounded).
    task automatic wait_edges(input int which, input logic val, output int n);
        n = 0;
        do begin
            tick(1);
            n++;
        end while (sig_of(which) !== val && n < 64);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        left_req = 1'b0;
        right_ack = 1'b0;
        tick(SYNC + 3);
        rst_n = 1'b1;
        tick(1);
    endtask

    // One legal nested handshake with random environment delays.
    task automatic legal_cycle(input int idx);
        int n;
        int hold;
        bit held_ok;
        left_req = 1'b1;
        wait_edges(0, 1'b1, n);
        check("R2 request latency", n == lat_short(), n, lat_short());
        check("R6 left_ack low at right_req rise", left_ack == 1'b0, left_ack, 0);
        hold = (idx % 5 == 0) ? 20 : int'($urandom_range(0, 6));
        held_ok = 1'b1;
        for (int i = 0; i < hold; i++) begin
            tick(1);
            if (right_req !== 1'b1 || left_ack !== 1'b0) held_ok = 1'b0;
        end
        check("R7 waiting holds request", held_ok, held_ok, 1);
        right_ack = 1'b1;
        wait_edges(0, 1'b0, n);
        check("R3 request release latency", n == lat_long(), n, lat_long());
        hold = int'($urandom_range(0, 8));
        held_ok = 1'b1;
        for (int i = 0; i < hold; i++) begin
            tick(1);
            if (left_ack !== 1'b0 || right_req !== 1'b0) held_ok = 1'b0;
        end
        check("R4 ack held while right_ack high", held_ok, held_ok, 1);
        right_ack = 1'b0;
        wait_edges(1, 1'b1, n);
        check("R4 ack latency", n == lat_short(), n, lat_short());
        check("R6 right_req low at left_ack rise", right_req == 1'b0, right_req, 0);
        tick(int'($urandom_range(0, 5)));
        left_req = 1'b0;
        wait_edges(1, 1'b0, n);
        check("R5 ack release latency", n == lat_long(), n, lat_long());
        check("R6 right_req stays low", right_req == 1'b0, right_req, 0);
        check("R9 no error in legal run", proto_err == 1'b0, proto_err, 0);
        tick(int'($urandom_range(0, 4)));
    endtask

    initial begin
        int n;
        void'($urandom(32'h5EED_1234));
        do_reset();
        check("R1 reset right_req", right_req == 1'b0, right_req, 0);
        check("R1 reset left_ack", left_ack == 1'b0, left_ack, 0);
        check("R1 reset proto_err", proto_err == 1'b0, proto_err, 0);

        // R6 and R11: repeated legal cycles with random latencies.
        for (int c = 0; c < N_CYCLES; c++) legal_cycle(c);

        // R8: stray acknowledge while idle.
        right_ack = 1'b1;
        tick(SYNC + 4);
        check("R8 stray ack flags error", proto_err == 1'b1, proto_err, 1);
        right_ack = 1'b0;
        tick(10);
        check("R10 error sticky", proto_err == 1'b1, proto_err, 1);

        do_reset();
        check("R1 reset clears error", proto_err == 1'b0, proto_err, 0);

        // R9: upstream request withdrawn before acknowledge.
        left_req = 1'b1;
        wait_edges(0, 1'b1, n);
        check("R2 request latency after reset", n == lat_short(), n, lat_short());
        left_req = 1'b0;
        tick(SYNC + 4);
        check("R9 early withdrawal flags error", proto_err == 1'b1, proto_err, 1);
        check("R9 left_ack never raised", left_ack == 1'b0, left_ack, 0);
        tick(8);
        check("R10 error still set", proto_err == 1'b1, proto_err, 1);

        do_reset();
        legal_cycle(1);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // R11: independent edge monitor on outputs during the whole run.
    logic prev_rr = 1'b0;
    logic prev_la = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !proto_err && (right_req !== prev_rr) && (left_ack !== prev_la))
            check("R11 simultaneous output change", 1'b0, 1, 0);
        prev_rr <= right_req;
        prev_la <= left_ack;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule